// File: doc/BRIEF.md
# Flash Instruction Prefetch Buffer

This block sits between a 32-bit instruction fetch port and a slow flash array whose every read returns a 128-bit line of four consecutive instructions. One flash read takes several processor clocks. Without help, the processor would run at the flash rate. The block keeps two line registers. The current line serves fetches at once. The second register holds the next sequential line, which is fetched ahead of use. As a result, straight-line code is served almost entirely out of local storage.

The fetch port works as a handshake. The processor holds a request and an address. The block raises ready with the instruction word in the same cycle whenever the line is already held. On the flash side, the block issues a one-cycle request carrying a line address. The flash answers with a valid pulse and the line exactly `FLASH_LAT` cycles later. It may accept a new request every cycle.

A branch to a line that neither register holds throws away both lines and any read still in flight. The block then issues a demand read and stalls the processor until that line is installed. A flush input empties the block in one cycle. The timing is fully deterministic: every stall length depends only on the fetch sequence and on `FLASH_LAT`.

Top module: `flash_prefetch_buf`

## Requirements
- R1: After reset both line registers are empty. With no request, ready and flash request are low, and the first fetch after reset is a miss.
- R2: A line holds word k in bits [32k+31:32k]. Fetch address bits [3:2] choose k, and bits [1:0] do not change the returned word.
- R3: A fetch whose line is the current line completes in the cycle it is presented, with zero stall cycles.
- R4: A fetch to a line that is neither held nor being read is a miss. In that cycle the block raises the flash request with line address = fetch address [ADDR_W-1:4]. Ready stays low for exactly FLASH_LAT+1 cycles, then the correct word is returned. No miss stalls longer than this.
- R5: The cycle after a line is installed with no next line held or pending, the block requests line+1 on its own. After enough idle cycles, a fetch to line+1 completes with zero stall.
- R6: A fetch that hits the prefetched line completes in the same cycle. That line becomes current, and in that same cycle the block requests the line after it.
- R7: A fetch to a line whose read is already in flight waits for it and does not issue a second read. In back-to-back sequential fetching, each line crossing stalls max(FLASH_LAT-3, 0) cycles.
- R8: A miss discards the prefetched line, both when it has already arrived and when it is still in flight. A later fetch to the discarded line is a miss again, and a stale return never corrupts a held line.
- R9: In a cycle with flush high, ready and flash request are low. Both registers and all pending reads are dropped, so the next fetch to any line is a full miss.
- R10: Flash data is accepted only in the cycle exactly FLASH_LAT cycles after the matching request. The prefetch line address wraps from the all-ones line to line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate both lines and drop pending reads |
| cpu_req_i | input | 1 | Fetch request, held until ready |
| cpu_addr_i | input | ADDR_W | Fetch byte address, held stable while waiting |
| cpu_ready_o | output | 1 | Fetch completes this cycle |
| cpu_rdata_o | output | 32 | Instruction word, valid with ready |
| fl_req_o | output | 1 | One-cycle flash read request |
| fl_line_o | output | ADDR_W-4 | Line address of the flash read |
| fl_rvalid_i | input | 1 | Flash line valid, FLASH_LAT cycles after request |
| fl_rdata_i | input | 128 | Flash line data |

## Verification
The bench uses four kinds of fetch pattern, each with its own stall count worked out from the latency:

- Unbroken sequential runs give one short stall per line crossing. This separates a working look-ahead from one that re-reads lines.
- Fetches after idle gaps should cost nothing. This shows that prefetch starts on its own.
- Branches away and back, including a branch taken while a prefetch is still in flight, must each cost exactly a full miss. This shows that discarded lines are really gone and that late returns are ignored.
- Flushes, wrap-around at the top of the address space, and a random mix of sequential, in-line and far jumps check that data matches a flat memory model and that no stall exceeds a full miss.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 4;

    typedef enum logic [2:0] {
        FC_NONE,
        FC_HIT_CUR,
        FC_HIT_PF,
        FC_WAIT,
        FC_MISS
    } fetch_cls_e;
endpackage

// File: rtl/fpb_line_buf.sv
module fpb_line_buf #(
    parameter int TAG_W  = 28,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic [LINE_W-1:0] data_i,
    input  logic [TAG_W-1:0]  cmp_tag_i,
    output logic              valid_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic              hit_o,
    output logic [LINE_W-1:0] line_o
);
    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [LINE_W-1:0] data;
    } lb_state_t;

    lb_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.vld = 1'b0;
        end else if (load_i) begin
            s_d.vld  = 1'b1;
            s_d.tag  = tag_i;
            s_d.data = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid_o = s_q.vld;
    assign tag_o   = s_q.tag;
    assign line_o  = s_q.data;
    assign hit_o   = s_q.vld && (s_q.tag == cmp_tag_i);

    // R8/R9: a clear request leaves the register empty on the next cycle
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !valid_o);
endmodule

// File: rtl/fpb_rd_track.sv
module fpb_rd_track #(
    parameter int LAT   = 4,
    parameter int TAG_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             kill_i,
    input  logic             rvalid_i,
    output logic             pend_o,
    output logic [TAG_W-1:0] tag_o,
    output logic             land_o
);
    localparam int CNT_W = $clog2(LAT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [TAG_W-1:0] tag;
    } rt_state_t;

    rt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (issue_i) begin
            s_d.cnt = CNT_W'(LAT);
            s_d.tag = tag_i;
        end else if (kill_i) begin
            s_d.cnt = '0;
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_o = (s_q.cnt != '0);
    assign tag_o  = s_q.tag;
    assign land_o = (s_q.cnt == CNT_W'(1)) && rvalid_i;

    // R10: the flash must answer in the cycle the tracker expects the line
    a_r10_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CNT_W'(1)) |-> rvalid_i);
endmodule

// File: rtl/flash_prefetch_buf.sv
module flash_prefetch_buf
    import fpb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int FLASH_LAT = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush_i,
    input  logic                           cpu_req_i,
    input  logic [ADDR_W-1:0]              cpu_addr_i,
    output logic                           cpu_ready_o,
    output logic [WORD_W-1:0]              cpu_rdata_o,
    output logic                           fl_req_o,
    output logic [ADDR_W-$clog2(WORD_W*LINE_WORDS/8)-1:0] fl_line_o,
    input  logic                           fl_rvalid_i,
    input  logic [WORD_W*LINE_WORDS-1:0]   fl_rdata_i
);
    localparam int LINE_W = WORD_W * LINE_WORDS;
    localparam int OFS_W  = $clog2(LINE_W / 8);
    localparam int SEL_W  = $clog2(LINE_WORDS);
    localparam int TAG_W  = ADDR_W - OFS_W;

    typedef struct packed {
        fetch_cls_e       cls;
        logic             ready;
        logic             dm_issue;
        logic             pf_issue;
        logic [TAG_W-1:0] pf_tgt;
        logic             cur_clr;
        logic             cur_load;
        logic             cur_src_pf;
        logic             pf_clr;
        logic             pf_load;
        logic             kill_pf;
        logic             kill_dm;
    } ctl_t;

    ctl_t c;

    logic [TAG_W-1:0]  req_tag;
    logic [SEL_W-1:0]  req_sel;
    logic              cur_vld, cur_hit, pf_vld, pf_hit;
    logic [TAG_W-1:0]  cur_tag, pf_tag;
    logic [LINE_W-1:0] cur_line, pf_line, sel_line;
    logic              pf_pend, dm_pend, pf_land, dm_land;
    logic [TAG_W-1:0]  pf_trk_tag, dm_trk_tag;
    logic              in_flight;
    logic [WORD_W-1:0] words [LINE_WORDS];

    assign req_tag = cpu_addr_i[ADDR_W-1:OFS_W];
    assign req_sel = SEL_W'(cpu_addr_i[OFS_W-1:0] >> 2);

    fpb_line_buf #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_cur (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (c.cur_clr),
        .load_i    (c.cur_load),
        .tag_i     (c.cur_src_pf ? pf_tag : dm_trk_tag),
        .data_i    (c.cur_src_pf ? pf_line : fl_rdata_i),
        .cmp_tag_i (req_tag),
        .valid_o   (cur_vld),
        .tag_o     (cur_tag),
        .hit_o     (cur_hit),
        .line_o    (cur_line)
    );

    fpb_line_buf #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_pf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (c.pf_clr),
        .load_i    (c.pf_load),
        .tag_i     (pf_trk_tag),
        .data_i    (fl_rdata_i),
        .cmp_tag_i (req_tag),
        .valid_o   (pf_vld),
        .tag_o     (pf_tag),
        .hit_o     (pf_hit),
        .line_o    (pf_line)
    );

    fpb_rd_track #(.LAT(FLASH_LAT), .TAG_W(TAG_W)) u_dm_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_i  (c.dm_issue),
        .tag_i    (req_tag),
        .kill_i   (c.kill_dm),
        .rvalid_i (fl_rvalid_i),
        .pend_o   (dm_pend),
        .tag_o    (dm_trk_tag),
        .land_o   (dm_land)
    );

    fpb_rd_track #(.LAT(FLASH_LAT), .TAG_W(TAG_W)) u_pf_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_i  (c.pf_issue),
        .tag_i    (c.pf_tgt),
        .kill_i   (c.kill_pf),
        .rvalid_i (fl_rvalid_i),
        .pend_o   (pf_pend),
        .tag_o    (pf_trk_tag),
        .land_o   (pf_land)
    );

    assign in_flight = (pf_pend && (req_tag == pf_trk_tag)) ||
                       (dm_pend && (req_tag == dm_trk_tag));

    always_comb begin
        c        = '0;
        c.cls    = FC_NONE;
        c.pf_tgt = cur_tag + TAG_W'(1);
        if (flush_i) begin
            c.cur_clr = 1'b1;
            c.pf_clr  = 1'b1;
            c.kill_pf = 1'b1;
            c.kill_dm = 1'b1;
        end else begin
            if (cpu_req_i) begin
                if (cur_hit)        c.cls = FC_HIT_CUR;
                else if (pf_hit)    c.cls = FC_HIT_PF;
                else if (in_flight) c.cls = FC_WAIT;
                else                c.cls = FC_MISS;
            end
            c.ready = (c.cls == FC_HIT_CUR) || (c.cls == FC_HIT_PF);
            if (c.cls == FC_MISS) begin
                c.dm_issue = 1'b1;
                c.cur_clr  = 1'b1;
                c.pf_clr   = 1'b1;
                c.kill_pf  = 1'b1;
            end else begin
                if (c.cls == FC_HIT_PF) begin
                    c.cur_load   = 1'b1;
                    c.cur_src_pf = 1'b1;
                    c.pf_clr     = 1'b1;
                    c.pf_issue   = 1'b1;
                    c.pf_tgt     = pf_tag + TAG_W'(1);
                end else begin
                    if (cur_vld && !pf_vld && !pf_pend && !dm_pend)
                        c.pf_issue = 1'b1;
                    if (dm_land)
                        c.cur_load = 1'b1;
                end
                if (pf_land)
                    c.pf_load = 1'b1;
            end
        end
    end

    assign sel_line = cur_hit ? cur_line : pf_line;

    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_word
        assign words[g] = sel_line[g*WORD_W +: WORD_W];
    end

    assign cpu_ready_o = c.ready;
    assign cpu_rdata_o = words[req_sel];
    assign fl_req_o    = c.dm_issue || c.pf_issue;
    assign fl_line_o   = c.dm_issue ? req_tag : c.pf_tgt;

    // R9: nothing survives a flush, so the following cycle cannot complete a fetch
    a_r9_flush_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !cpu_ready_o);

    // R4: a demand read keeps the processor stalled through the next cycle
    a_r4_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req_o && cpu_req_i && !cpu_ready_o) |=> !cpu_ready_o);

    // R6: consuming the prefetched line requests the following line in the same cycle
    a_r6_chain_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_i && cpu_ready_o && !cur_hit) |->
        (fl_req_o && (fl_line_o == req_tag + TAG_W'(1))));

    // R7: waiting on a line already in flight issues no duplicate read
    a_r7_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_i && !flush_i && !cur_hit && pf_pend && (req_tag == pf_trk_tag))
        |-> !fl_req_o);

    // R3: ready only ever answers a request
    a_r3_ready_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready_o |-> cpu_req_i);
endmodule

// File: tb/sim_flash_prefetch_buf.sv
module sim_flash_prefetch_buf;
    localparam int CLK_P = 10;
    localparam int LAT   = 4;
    localparam int AW    = 32;
    localparam int TW    = AW - 4;
    localparam int MISS  = LAT + 1;
    localparam int XS    = (LAT > 3) ? LAT - 3 : 0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          cpu_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_ready;
    logic [31:0]   cpu_rdata;
    logic          fl_req;
    logic [TW-1:0] fl_line;
    logic          fl_rvalid;
    logic [127:0]  fl_rdata;

    int vectors = 0;
    int fails   = 0;
    logic          first_req, hit_req;
    logic [TW-1:0] first_line, hit_line;

    always #(CLK_P/2) clk = ~clk;

    flash_prefetch_buf #(.ADDR_W(AW), .FLASH_LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .flush_i(flush),
        .cpu_req_i(cpu_req), .cpu_addr_i(cpu_addr),
        .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rdata),
        .fl_req_o(fl_req), .fl_line_o(fl_line),
        .fl_rvalid_i(fl_rvalid), .fl_rdata_i(fl_rdata)
    );

    function automatic logic [31:0] mw(input logic [31:0] a);
        logic [31:0] x;
        x = {a[31:2], 2'b00};
        return (x * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [127:0] line_data(input logic [TW-1:0] ln);
        logic [127:0] d;
        for (int k = 0; k < 4; k++) d[k*32 +: 32] = mw({ln, 4'(k*4)});
        return d;
    endfunction

    // flat flash model: fixed latency, pipelined
    logic          fv [LAT];
    logic [TW-1:0] fa [LAT];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                fv[i] <= 1'b0;
                fa[i] <= '0;
            end
        end else begin
            fv[0] <= fl_req;
            fa[0] <= fl_line;
            for (int i = 1; i < LAT; i++) begin
                fv[i] <= fv[i-1];
                fa[i] <= fa[i-1];
            end
        end
    end
    assign fl_rvalid = fv[LAT-1];
    assign fl_rdata  = line_data(fa[LAT-1]);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    task automatic do_fetch(input logic [31:0] a, output logic [31:0] d, output int st);
        int guard;
        bit done;
        cpu_req = 1'b1; cpu_addr = a; st = 0; done = 0; guard = 0; d = '0;
        while (!done && guard < 60) begin
            #(CLK_P/4);
            if (guard == 0) begin first_req = fl_req; first_line = fl_line; end
            if (cpu_ready) begin
                d = cpu_rdata; hit_req = fl_req; hit_line = fl_line; done = 1;
            end else st++;
            guard++;
            @(negedge clk);
        end
    endtask

    task automatic fetch_chk(input logic [31:0] a, input int exp_st, input string tag);
        logic [31:0] d;
        int st;
        do_fetch(a, d, st);
        chk(d == mw(a), {tag, " data"}, d, mw(a));
        if (exp_st >= 0) chk(st == exp_st, {tag, " stall"}, st, exp_st);
    endtask

    task automatic idle(input int n);
        cpu_req = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] a;
        logic [31:0] d;
        int st;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #(CLK_P/4);
        chk(!cpu_ready && !fl_req, "R1 reset quiet", {cpu_ready, fl_req}, 0);
        @(negedge clk);

        // R1/R4: cold miss
        fetch_chk(32'h100, MISS, "R1 R4 cold miss");
        chk(first_req && first_line == TW'(32'h10), "R4 demand line", {3'b0, first_line, first_req}, {3'b0, 28'h10, 1'b1});
        // R3: rest of the current line
        fetch_chk(32'h104, 0, "R3 hit w1");
        fetch_chk(32'h108, 0, "R3 hit w2");
        fetch_chk(32'h10C, 0, "R3 hit w3");
        // R7/R6: sequential crossing into prefetched line
        fetch_chk(32'h110, XS, "R7 crossing");
        chk(hit_req && hit_line == TW'(32'h12), "R6 chained prefetch", {3'b0, hit_line, hit_req}, {3'b0, 28'h12, 1'b1});
        fetch_chk(32'h114, 0, "R3 hit");
        fetch_chk(32'h118, 0, "R3 hit");
        fetch_chk(32'h11C, 0, "R3 hit");
        fetch_chk(32'h120, XS, "R7 second crossing");
        // R5: prefetch completes during idle time
        idle(10);
        fetch_chk(32'h130, 0, "R5 idle prefetch");
        // R2: low address bits ignored, bits [3:2] select the word
        fetch_chk(32'h13B, 0, "R2 byte offset");
        chk(mw(32'h13B) == mw(32'h138), "R2 model", mw(32'h13B), mw(32'h138));
        // R8: completed prefetch discarded by branch
        idle(8);
        fetch_chk(32'h800, MISS, "R8 branch miss");
        idle(8);
        fetch_chk(32'h140, MISS, "R8 discarded line");
        // R8: in-flight prefetch discarded
        fetch_chk(32'h900, MISS, "R8 branch in flight");
        fetch_chk(32'h904, 0, "R8 hit after branch");
        idle(8);
        fetch_chk(32'h910, 0, "R8 fresh prefetch intact");
        // R9: flush
        flush = 1'b1; cpu_req = 1'b1; cpu_addr = 32'h914;
        #(CLK_P/4);
        chk(!cpu_ready && !fl_req, "R9 flush cycle quiet", {cpu_ready, fl_req}, 0);
        @(negedge clk);
        flush = 1'b0;
        fetch_chk(32'h914, MISS, "R9 after flush");
        // R9/R10: flush while a demand read is in flight
        cpu_req = 1'b1; cpu_addr = 32'hA00;
        repeat (2) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        fetch_chk(32'hA00, MISS, "R10 stale return ignored");
        // R10: line address wraps
        fetch_chk(32'hFFFF_FFFC, MISS, "R10 top line");
        idle(8);
        fetch_chk(32'h0000_0000, 0, "R10 wrap prefetch");

        // random mix
        a = 32'h200;
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 65) a = a + 32'd4;
            else if (r < 75) a = {a[31:4], 4'($urandom)};
            else if (r < 97) a = $urandom % 32'h400;
            else begin
                idle(1);
                flush = 1'b1;
                @(negedge clk);
                flush = 1'b0;
                continue;
            end
            do_fetch(a, d, st);
            chk(d == mw(a), "R2 R3 random data", d, mw(a));
            chk(st <= MISS, "R4 random stall bound", st, MISS);
        end
        idle(2);
        summary();
        $finish;
    end
endmodule